// File: doc/BRIEF.md
# Way-Partitioned Cache Size Selector

This block decides how many ways of a four-way cache belong to the fast primary partition. The rest form the slower secondary partition. Each lookup probes the primary partition first. A lookup that misses there probes the secondary partition, and a hit in the secondary partition swaps the block between the two.

The cache keeps a full recency order in every set. For each access it reports the recency position at which the line was found (0 is the most recent), or reports a miss. This block counts accesses per recency position and counts misses. From those counts it can rebuild, for any primary size k, the number of primary hits (positions below k), secondary hits (positions k and above) and misses. No other configuration has to be tried.

At the end of each instruction interval the counts are frozen and the counters start again. For each of the four sizes, a sequential engine forms a latency-weighted access count and multiplies it by that size's clock period. It then reports the cheapest size for the next interval with a one-cycle strobe.

Top module: `wpc_reconfig_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cfg_ways` reads 1 and `cfg_valid` is low until the first decision completes.
- R2: There is one saturating counter of CNT_W bits for each recency position (`acc_hit_pos` = 0..3) and one for misses. A counter at 2^CNT_W-1 holds that value instead of wrapping.
- R3: An interval ends on the INTERVAL-th `inst_retire` strobe. At that edge the counts are frozen for evaluation and all counters restart. An access presented in the same cycle as that strobe counts toward the next interval. No decision is issued before that strobe.
- R4: For a primary size of k ways (1..4), primary hits are the sum of positions 0..k-1 and secondary hits are the sum of positions k..3.
- R5: The cost of size k is (primary hits × A_LAT + secondary hits × B_LAT[k] + misses × MISS_PEN) × PERIOD[k]. With the defaults, A_LAT is 2, B_LAT is 8/5/2/0, PERIOD is 100/125/150/175 for k = 1/2/3/4, and MISS_PEN is 20. With k = 4 there are no secondary hits.
- R6: The size with the lowest cost is chosen. On a tie the smaller size wins, so an interval with no accesses selects 1 way.
- R7: `cfg_valid` is high for exactly one cycle per decision, within 4×(PER_W+2)+1 cycles of the interval end. `cfg_ways` changes only in the cycle in which `cfg_valid` is high, and it always lies in 1..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_hit | input | 1 | Access hit this cycle |
| acc_hit_pos | input | 2 | Recency position of the hit, 0 = most recent |
| acc_miss | input | 1 | Access missed in every way this cycle |
| inst_retire | input | 1 | One instruction retired this cycle |
| cfg_ways | output | 3 | Selected primary partition size, 1..4 |
| cfg_valid | output | 1 | One-cycle strobe marking a new decision |

## Verification
The assertions check on every cycle that the counters hold at saturation and otherwise step by one, that the interval count stays in range, that the engine starts only when idle, and that the decision strobe lasts one cycle. They also check that the selected size is held between strobes and stays in 1..4. Only the bench scenarios can show that the chosen size is the cheapest for a given mix of recency positions and misses, and that ties resolve to the smaller size. The same holds for counts being cleared between intervals, an access in the closing cycle landing in the next interval, and saturation changing the outcome relative to wrap-around.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   localparam int NWAYS = 4;
   localparam int POS_W = $clog2(NWAYS);
   localparam int CFG_W = $clog2(NWAYS + 1);

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_SUM,
      ENG_MUL,
      ENG_CMP
   } eng_state_t;
endpackage

// File: rtl/wpc_sat_counter.sv
module wpc_sat_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             restart,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] SAT = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= CNT_W'(inc);
      else if (inc && (cnt_q != SAT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign value = cnt_q;

   assert_hold_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == SAT && !restart) |=> (cnt_q == SAT));

   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !restart && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wpc_pos_counters.sv
module wpc_pos_counters
   import wpc_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ev_hit,
   input  logic [POS_W-1:0]            ev_pos,
   input  logic                        ev_miss,
   input  logic                        restart,
   output logic [NWAYS-1:0][CNT_W-1:0] pos_cnt,
   output logic [CNT_W-1:0]            miss_cnt
);
   generate
      for (genvar p = 0; p < NWAYS; p++) begin : g_pos
         logic             bump;
         logic [CNT_W-1:0] val;
         assign bump = ev_hit && (ev_pos == POS_W'(p));
         wpc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (bump),
            .restart (restart),
            .value   (val)
         );
         assign pos_cnt[p] = val;
      end
   endgenerate

   wpc_sat_counter #(.CNT_W(CNT_W)) u_miss (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (ev_miss),
      .restart (restart),
      .value   (miss_cnt)
   );

   assert_excl_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_hit && ev_miss));
endmodule

// File: rtl/wpc_interval_timer.sv
module wpc_interval_timer #(
   parameter int INTERVAL = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic wrap
);
   localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

   logic [IW-1:0] cnt_q;

   assign wrap = tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wrap)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));
endmodule

// File: rtl/wpc_cost_engine.sv
module wpc_cost_engine
   import wpc_pkg::*;
#(
   parameter int                      CNT_W    = 15,
   parameter int                      COST_W   = 36,
   parameter int                      LAT_W    = 8,
   parameter int                      PER_W    = 8,
   parameter int                      A_LAT    = 2,
   parameter int                      MISS_PEN = 20,
   parameter logic [NWAYS*LAT_W-1:0]  B_LAT_V  = {8'd0, 8'd2, 8'd5, 8'd8},
   parameter logic [NWAYS*PER_W-1:0]  PERIOD_V = {8'd175, 8'd150, 8'd125, 8'd100}
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [NWAYS-1:0][CNT_W-1:0] snap_pos,
   input  logic [CNT_W-1:0]            snap_miss,
   output logic                        dec_valid,
   output logic [CFG_W-1:0]            dec_ways
);
   localparam int BW = $clog2(PER_W + 1);

   eng_state_t                  state_q;
   logic [POS_W-1:0]            k_q;
   logic [NWAYS-1:0][CNT_W-1:0] pos_q;
   logic [CNT_W-1:0]            miss_q;
   logic [COST_W-1:0]           mcand_q;
   logic [PER_W-1:0]            mplier_q;
   logic [COST_W-1:0]           acc_q;
   logic [COST_W-1:0]           best_q;
   logic [POS_W-1:0]            best_k_q;
   logic [BW-1:0]               bit_q;

   logic [COST_W-1:0] a_sum, b_sum, weighted;
   logic [LAT_W-1:0]  b_lat;
   logic [PER_W-1:0]  period;
   logic              win;

   always_comb begin
      a_sum = '0;
      b_sum = '0;
      for (int p = 0; p < NWAYS; p++) begin
         if (p <= int'(k_q))
            a_sum = a_sum + COST_W'(pos_q[p]);
         else
            b_sum = b_sum + COST_W'(pos_q[p]);
      end
      b_lat    = B_LAT_V[int'(k_q)*LAT_W +: LAT_W];
      period   = PERIOD_V[int'(k_q)*PER_W +: PER_W];
      weighted = a_sum * COST_W'(A_LAT)
               + b_sum * COST_W'(b_lat)
               + COST_W'(miss_q) * COST_W'(MISS_PEN);
      win      = (k_q == '0) || (acc_q < best_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ENG_IDLE;
         k_q       <= '0;
         pos_q     <= '0;
         miss_q    <= '0;
         mcand_q   <= '0;
         mplier_q  <= '0;
         acc_q     <= '0;
         best_q    <= '0;
         best_k_q  <= '0;
         bit_q     <= '0;
         dec_valid <= 1'b0;
         dec_ways  <= CFG_W'(1);
      end else begin
         dec_valid <= 1'b0;
         case (state_q)
            ENG_IDLE: begin
               if (start) begin
                  pos_q   <= snap_pos;
                  miss_q  <= snap_miss;
                  k_q     <= '0;
                  state_q <= ENG_SUM;
               end
            end
            ENG_SUM: begin
               mcand_q  <= weighted;
               mplier_q <= period;
               acc_q    <= '0;
               bit_q    <= '0;
               state_q  <= ENG_MUL;
            end
            ENG_MUL: begin
               if (mplier_q[0])
                  acc_q <= acc_q + mcand_q;
               mcand_q  <= mcand_q << 1;
               mplier_q <= mplier_q >> 1;
               bit_q    <= bit_q + 1'b1;
               if (bit_q == BW'(PER_W - 1))
                  state_q <= ENG_CMP;
            end
            default: begin
               if (win) begin
                  best_q   <= acc_q;
                  best_k_q <= k_q;
               end
               if (k_q == POS_W'(NWAYS - 1)) begin
                  dec_valid <= 1'b1;
                  dec_ways  <= CFG_W'(win ? k_q : best_k_q) + CFG_W'(1);
                  state_q   <= ENG_IDLE;
               end else begin
                  k_q     <= k_q + 1'b1;
                  state_q <= ENG_SUM;
               end
            end
         endcase
      end
   end

   assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (state_q == ENG_IDLE));

   assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   assert_best_le_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_CMP && k_q != '0) |=> (best_q <= $past(acc_q)));
endmodule

// File: rtl/wpc_reconfig_ctrl.sv
module wpc_reconfig_ctrl
   import wpc_pkg::*;
#(
   parameter int                      INTERVAL = 15000,
   parameter int                      CNT_W    = 15,
   parameter int                      COST_W   = 36,
   parameter int                      LAT_W    = 8,
   parameter int                      PER_W    = 8,
   parameter int                      A_LAT    = 2,
   parameter int                      MISS_PEN = 20,
   parameter logic [NWAYS*LAT_W-1:0]  B_LAT_V  = {8'd0, 8'd2, 8'd5, 8'd8},
   parameter logic [NWAYS*PER_W-1:0]  PERIOD_V = {8'd175, 8'd150, 8'd125, 8'd100}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_hit,
   input  logic [1:0]       acc_hit_pos,
   input  logic             acc_miss,
   input  logic             inst_retire,
   output logic [2:0]       cfg_ways,
   output logic             cfg_valid
);
   localparam int DEC_CYCLES = NWAYS * (PER_W + 2) + 1;
   localparam int MIN_COST_W = CNT_W + 2 + LAT_W + 2 + PER_W;

   generate
      if (INTERVAL <= DEC_CYCLES) begin : g_bad_interval
         $error("INTERVAL must exceed the decision time");
      end
      if (COST_W < MIN_COST_W) begin : g_bad_cost_w
         $error("COST_W too narrow for the weighted product");
      end
      if (POS_W != 2 || CFG_W != 3) begin : g_bad_ways
         $error("port widths assume a four-way cache");
      end
   endgenerate

   logic                        wrap;
   logic [NWAYS-1:0][CNT_W-1:0] pos_cnt;
   logic [CNT_W-1:0]            miss_cnt;

   wpc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (inst_retire),
      .wrap  (wrap)
   );

   wpc_pos_counters #(.CNT_W(CNT_W)) u_counters (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_hit   (acc_hit),
      .ev_pos   (acc_hit_pos),
      .ev_miss  (acc_miss),
      .restart  (wrap),
      .pos_cnt  (pos_cnt),
      .miss_cnt (miss_cnt)
   );

   wpc_cost_engine #(
      .CNT_W    (CNT_W),
      .COST_W   (COST_W),
      .LAT_W    (LAT_W),
      .PER_W    (PER_W),
      .A_LAT    (A_LAT),
      .MISS_PEN (MISS_PEN),
      .B_LAT_V  (B_LAT_V),
      .PERIOD_V (PERIOD_V)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (wrap),
      .snap_pos  (pos_cnt),
      .snap_miss (miss_cnt),
      .dec_valid (cfg_valid),
      .dec_ways  (cfg_ways)
   );

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |-> $stable(cfg_ways));

   assert_cfg_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ways >= 3'd1) && (cfg_ways <= 3'd4));
endmodule

// File: tb/sim_wpc_reconfig_ctrl.sv
`timescale 1ns/1ps
module sim_wpc_reconfig_ctrl;
   localparam int INTERVAL = 64;
   localparam int SAT      = 32767;
   localparam int BOUND    = 4 * (8 + 2) + 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_hit = 1'b0;
   logic [1:0] acc_hit_pos = 2'd0;
   logic       acc_miss = 1'b0;
   logic       inst_retire = 1'b0;
   logic [2:0] cfg_ways;
   logic       cfg_valid;

   int n_checks = 0;
   int n_fail   = 0;
   int m_pos [4];
   int m_miss;
   int blat [4] = '{8, 5, 2, 0};
   int per  [4] = '{100, 125, 150, 175};

   always #5 clk = ~clk;

   wpc_reconfig_ctrl #(.INTERVAL(INTERVAL)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_hit     (acc_hit),
      .acc_hit_pos (acc_hit_pos),
      .acc_miss    (acc_miss),
      .inst_retire (inst_retire),
      .cfg_ways    (cfg_ways),
      .cfg_valid   (cfg_valid)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_ways();
      longint best = 0;
      int     bk = 1;
      for (int k = 1; k <= 4; k++) begin
         longint a = 0, b = 0, c;
         for (int p = 0; p < 4; p++) begin
            if (p < k) a += m_pos[p];
            else       b += m_pos[p];
         end
         c = (a * 2 + b * blat[k-1] + longint'(m_miss) * 20) * per[k-1];
         if (k == 1 || c < best) begin
            best = c;
            bk = k;
         end
      end
      return bk;
   endfunction

   task automatic model_clear();
      for (int p = 0; p < 4; p++) m_pos[p] = 0;
      m_miss = 0;
   endtask

   task automatic hits(input int pos, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc_hit = 1'b1;
         acc_hit_pos = 2'(pos);
         if (m_pos[pos] < SAT) m_pos[pos]++;
      end
      @(negedge clk);
      acc_hit = 1'b0;
   endtask

   task automatic misses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc_miss = 1'b1;
         if (m_miss < SAT) m_miss++;
      end
      @(negedge clk);
      acc_miss = 1'b0;
   endtask

   // Closes an interval; optionally places a pos-3 hit in the closing cycle.
   task automatic close_interval(input string req, input bit edge_hit);
      int  expw;
      int  prev;
      bit  early = 0;
      bit  held = 1;
      bit  got = 0;
      int  waited = 0;
      prev = int'(cfg_ways);
      for (int i = 0; i < INTERVAL - 1; i++) begin
         @(negedge clk);
         inst_retire = 1'b1;
         if (cfg_valid) early = 1;
      end
      @(negedge clk);
      inst_retire = 1'b0;
      for (int i = 0; i < BOUND; i++) begin
         @(negedge clk);
         if (cfg_valid) early = 1;
      end
      check(!early, "R3 no decision before last retire", early, 0);
      expw = model_ways();
      model_clear();
      @(negedge clk);
      inst_retire = 1'b1;
      if (edge_hit) begin
         acc_hit = 1'b1;
         acc_hit_pos = 2'd3;
         m_pos[3] = 1;
      end
      for (int c = 0; c < BOUND + 10; c++) begin
         @(negedge clk);
         inst_retire = 1'b0;
         acc_hit = 1'b0;
         waited++;
         if (cfg_valid) begin
            got = 1;
            break;
         end
         if (int'(cfg_ways) != prev) held = 0;
      end
      check(got && waited <= BOUND, "R7 decision latency", waited, BOUND);
      check(held, "R7 cfg held before strobe", cfg_ways, prev);
      check(int'(cfg_ways) == expw, req, cfg_ways, expw);
      @(negedge clk);
      check(!cfg_valid, "R7 strobe one cycle", cfg_valid, 0);
      check(int'(cfg_ways) == expw, "R7 cfg held after strobe", cfg_ways, expw);
   endtask

   task automatic t_reset();
      model_clear();
      repeat (3) @(negedge clk);
      check(cfg_ways == 3'd1, "R1 reset cfg", cfg_ways, 1);
      check(!cfg_valid, "R1 reset valid", cfg_valid, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(cfg_ways == 3'd1 && !cfg_valid, "R1 after release", cfg_ways, 1);
   endtask

   task automatic t_pos0();
      hits(0, 20);
      close_interval("R4 pos0 hits choose 1 way", 0);
   endtask

   task automatic t_pos3();
      hits(3, 20);
      close_interval("R5 pos3 hits choose 3 ways", 0);
      check(cfg_ways == 3'd3, "R5 pos3 literal", cfg_ways, 3);
   endtask

   task automatic t_cleared();
      hits(0, 10);
      close_interval("R3 counters restart each interval", 0);
      check(cfg_ways == 3'd1, "R3 old counts dropped", cfg_ways, 1);
   endtask

   task automatic t_tie();
      hits(3, 5);
      close_interval("R6 pre-tie setup", 0);
      close_interval("R6 empty interval tie picks 1", 0);
      check(cfg_ways == 3'd1, "R6 tie literal", cfg_ways, 1);
   endtask

   task automatic t_pos1();
      hits(1, 30);
      hits(0, 5);
      close_interval("R4 pos1 mix chooses 2 ways", 0);
      check(cfg_ways == 3'd2, "R4 pos1 literal", cfg_ways, 2);
   endtask

   task automatic t_misses();
      hits(2, 10);
      misses(40);
      close_interval("R5 miss heavy mix", 0);
      check(cfg_ways == 3'd1, "R5 miss literal", cfg_ways, 1);
   endtask

   task automatic t_edge();
      hits(0, 3);
      close_interval("R3 closing-cycle hit goes to next interval", 1);
      check(cfg_ways == 3'd1, "R3 edge literal", cfg_ways, 1);
      close_interval("R3 carried hit counted next interval", 0);
      check(cfg_ways == 3'd3, "R3 carried literal", cfg_ways, 3);
   endtask

   task automatic t_saturate();
      hits(0, 100);
      close_interval("R2 setup", 0);
      hits(0, 100);
      hits(3, SAT + 3);
      close_interval("R2 saturated counter decides 3 ways", 0);
      check(cfg_ways == 3'd3, "R2 saturation literal", cfg_ways, 3);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_pos0();
      t_pos3();
      t_cleared();
      t_tie();
      t_pos1();
      t_misses();
      t_edge();
      t_saturate();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule